// File: doc/BRIEF.md
# Registered Byte ALU with Carry and Zero Flags

This block is the arithmetic-logic stage of a small multi-cycle byte processor. Each cycle it takes two operands and a four-bit mode from the controller and works out one of ten functions: add, subtract, bitwise AND, OR, XOR, complement of the first operand, logical shifts in either direction and rotates in either direction. For the shifts and rotates, the second operand holds the number of bit positions to move.

The computed value does not reach the output directly. It is captured in a result register only on a cycle when the controller raises the load strobe. Carry and zero flags are captured on that same strobe, each in its own register, so that later branch and flag-read steps can use them. Operand selection (register or immediate), the register file and instruction decoding all live outside this block.

Top module: `alu8_unit`

## Requirements
- R1: A synchronous active-high reset clears the result register, the carry flag and the zero flag to 0.
- R2: The result, carry and zero outputs change only after a rising edge at which load is high. On any other edge they hold their values.
- R3: Mode 0 (add) loads the low 8 bits of a+b, and sets carry to the ninth bit of the sum.
- R4: Mode 1 (subtract) loads (a-b) mod 256. Carry is set exactly when a is less than b (a borrow occurs).
- R5: Mode 2 (AND), mode 3 (OR) and mode 5 (XOR) load the bitwise result of a and b, and clear carry.
- R6: Mode 4 (complement) loads the bitwise inverse of a, ignores b completely, and clears carry.
- R7: Mode 6 (shift left) loads a shifted left by b positions with zeros filled in at the bottom. Any b of 8 or more gives 0x00. Carry is cleared.
- R8: Mode 7 (shift right) loads a shifted right by b positions with zeros filled in at the top. Any b of 8 or more gives 0x00. Carry is cleared.
- R9: Mode 8 (rotate left) loads a rotated left by b mod 8 positions, with bit 7 wrapping into bit 0. Carry is cleared.
- R10: Mode 9 (rotate right) loads a rotated right by b mod 8 positions, with bit 0 wrapping into bit 7. Carry is cleared.
- R11: On every load, zero is set exactly when the 8-bit value loaded is 0x00.
- R12: Modes 10 to 15 are unused. They load 0x00, clear carry and set zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand, or the shift/rotate count |
| mode | input | 4 | Function select (0 add, 1 sub, 2 and, 3 or, 4 not, 5 xor, 6 shl, 7 shr, 8 rol, 9 ror) |
| load | input | 1 | Strobe that captures the result and both flags |
| result | output | 8 | Registered result |
| carry | output | 1 | Registered carry/borrow flag |
| zero | output | 1 | Registered zero flag |

## Verification
All state sits in three registers that drive the outputs directly. A wrong internal value therefore shows at the ports one edge after the load that captured it, and it stays visible until the next load or reset. The one exception is a fault in a shifter stage: it only shows for counts that set that stage's bit. The random operands and counts are chosen so that every stage is exercised with its bit both set and clear. Hold faults, where a register updates without a strobe, show on the first unloaded edge that sees different inputs.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
   localparam int MODE_W = 4;

   typedef enum logic [MODE_W-1:0] {
      OP_ADD = 4'd0,
      OP_SUB = 4'd1,
      OP_AND = 4'd2,
      OP_OR  = 4'd3,
      OP_NOT = 4'd4,
      OP_XOR = 4'd5,
      OP_SHL = 4'd6,
      OP_SHR = 4'd7,
      OP_ROL = 4'd8,
      OP_ROR = 4'd9
   } alu_op_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         cout
);
   logic [W:0] ext;

   // The extra top bit holds the carry of an add or the borrow of a subtract.
   always_comb begin
      if (sub) ext = {1'b0, a} - {1'b0, b};
      else     ext = {1'b0, a} + {1'b0, b};
   end

   assign sum  = ext[W-1:0];
   assign cout = ext[W];
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter #(
   parameter int W = 8
) (
   input  logic [W-1:0] val,
   input  logic [W-1:0] amt,
   input  logic         left,
   input  logic         rotate,
   output logic [W-1:0] out
);
   localparam int CNT_W = $clog2(W);

   if (W < 2 || W != (1 << CNT_W)) begin : g_bad_width
      $error("alu8_shifter: W must be a power of two, at least 2");
   end

   logic [W-1:0] stage [0:CNT_W];
   assign stage[0] = val;

   for (genvar s = 0; s < CNT_W; s++) begin : g_stage
      localparam int K = 1 << s;
      logic [W-1:0] l_sh, l_rot, r_sh, r_rot;
      assign l_sh  = {stage[s][W-1-K:0], {K{1'b0}}};
      assign l_rot = {stage[s][W-1-K:0], stage[s][W-1:W-K]};
      assign r_sh  = {{K{1'b0}}, stage[s][W-1:K]};
      assign r_rot = {stage[s][K-1:0], stage[s][W-1:K]};
      assign stage[s+1] = !amt[s] ? stage[s] :
                          left    ? (rotate ? l_rot : l_sh) :
                                    (rotate ? r_rot : r_sh);
   end

   // Count bits above the stage range: rotates wrap, shifts empty out.
   logic over;
   assign over = |amt[W-1:CNT_W];
   assign out  = (over && !rotate) ? '0 : stage[CNT_W];
endmodule

// File: rtl/alu8_state_reg.sv
module alu8_state_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] d_res,
   input  logic         d_carry,
   output logic [W-1:0] q_res,
   output logic         q_carry,
   output logic         q_zero
);
   always_ff @(posedge clk) begin
      if (rst) begin
         q_res   <= '0;
         q_carry <= 1'b0;
         q_zero  <= 1'b0;
      end else if (load) begin
         q_res   <= d_res;
         q_carry <= d_carry;
         q_zero  <= (d_res == '0);
      end
   end
endmodule

// File: rtl/alu8_unit.sv
module alu8_unit
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [MODE_W-1:0] mode,
   input  logic              load,
   output logic [DATA_W-1:0] result,
   output logic              carry,
   output logic              zero
);
   alu_op_e op;
   assign op = alu_op_e'(mode);

   logic [DATA_W-1:0] as_sum, sh_out, n_res;
   logic              as_cout, n_carry;

   alu8_addsub #(.W(DATA_W)) u_addsub (
      .a(op_a), .b(op_b), .sub(op == OP_SUB), .sum(as_sum), .cout(as_cout)
   );

   alu8_shifter #(.W(DATA_W)) u_shift (
      .val(op_a), .amt(op_b),
      .left(op == OP_SHL || op == OP_ROL),
      .rotate(op == OP_ROL || op == OP_ROR),
      .out(sh_out)
   );

   always_comb begin
      n_carry = 1'b0;
      case (op)
         OP_ADD, OP_SUB: begin
            n_res   = as_sum;
            n_carry = as_cout;
         end
         OP_AND: n_res = op_a & op_b;
         OP_OR:  n_res = op_a | op_b;
         OP_XOR: n_res = op_a ^ op_b;
         OP_NOT: n_res = ~op_a;
         OP_SHL, OP_SHR, OP_ROL, OP_ROR: n_res = sh_out;
         default: n_res = '0;
      endcase
   end

   alu8_state_reg #(.W(DATA_W)) u_state (
      .clk(clk), .rst(rst), .load(load),
      .d_res(n_res), .d_carry(n_carry),
      .q_res(result), .q_carry(carry), .q_zero(zero)
   );

   // R2: without a strobe, nothing moves
   a_r2_hold: assert property (@(posedge clk) disable iff (rst)
      !load |=> ($stable(result) && $stable(carry) && $stable(zero)));
   // R3: nine-bit sum lands in carry and result
   a_r3_add_carry: assert property (@(posedge clk) disable iff (rst)
      (load && mode == 4'd0) |=> ({carry, result} == {1'b0, $past(op_a)} + {1'b0, $past(op_b)}));
   // R4: borrow flag on subtract
   a_r4_borrow: assert property (@(posedge clk) disable iff (rst)
      (load && mode == 4'd1) |=> (carry == ($past(op_a) < $past(op_b))));
   // R6: complement of the first operand
   a_r6_not: assert property (@(posedge clk) disable iff (rst)
      (load && mode == 4'd4) |=> (result == DATA_W'(~$past(op_a))));
   // R5, R7..R10, R12: every non-arithmetic mode clears carry
   a_r5_carry_clear: assert property (@(posedge clk) disable iff (rst)
      (load && mode > 4'd1) |=> !carry);
   // R11: zero flag agrees with the loaded value
   a_r11_zero: assert property (@(posedge clk) disable iff (rst)
      load |=> (zero == (result == '0)));
endmodule

// File: tb/alu8_unit_bench.sv
`timescale 1ns/1ps
module alu8_unit_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] op_a = '0, op_b = '0;
   logic [3:0] mode = '0;
   logic       load = 1'b0;
   logic [7:0] result;
   logic       carry, zero;

   int checks = 0;
   int failures = 0;
   logic [7:0] e_res = '0;
   logic       e_car = 1'b0, e_zer = 1'b0;

   always #4 clk = ~clk;

   alu8_unit u_alu8_unit (
      .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .mode(mode),
      .load(load), .result(result), .carry(carry), .zero(zero)
   );

   function automatic logic [8:0] model(input logic [7:0] a, b, input logic [3:0] m);
      logic [15:0] dbl;
      dbl = {a, a};
      case (m)
         4'd0: return {1'b0, a} + {1'b0, b};
         4'd1: return {(a < b), 8'(a - b)};
         4'd2: return {1'b0, a & b};
         4'd3: return {1'b0, a | b};
         4'd4: return {1'b0, ~a};
         4'd5: return {1'b0, a ^ b};
         4'd6: return {1'b0, (b >= 8) ? 8'h00 : 8'(a << b)};
         4'd7: return {1'b0, (b >= 8) ? 8'h00 : 8'(a >> b)};
         4'd8: return {1'b0, dbl[15 - (b % 8) -: 8]};
         4'd9: return {1'b0, dbl[7 + (b % 8) -: 8]};
         default: return 9'd0;
      endcase
   endfunction

   function automatic string tag_of(input logic [3:0] m);
      case (m)
         4'd0: return "R3";
         4'd1: return "R4";
         4'd2, 4'd3, 4'd5: return "R5";
         4'd4: return "R6";
         4'd6: return "R7";
         4'd7: return "R8";
         4'd8: return "R9";
         4'd9: return "R10";
         default: return "R12";
      endcase
   endfunction

   task automatic check(input string req);
      checks++;
      if (result !== e_res || carry !== e_car || zero !== e_zer) begin
         failures++;
         $display("FAIL %s: got res=%h c=%b z=%b, expected res=%h c=%b z=%b",
                  req, result, carry, zero, e_res, e_car, e_zer);
      end
   endtask

   // Drive at a falling edge, let one rising edge pass, compare at the next falling edge.
   task automatic step(input logic [7:0] a, b, input logic [3:0] m, input logic ld, input string req);
      logic [8:0] r;
      @(negedge clk);
      op_a = a; op_b = b; mode = m; load = ld;
      @(negedge clk);
      if (ld) begin
         r = model(a, b, m);
         e_res = r[7:0]; e_car = r[8]; e_zer = (r[7:0] == 8'h00);
      end
      check(req);
   endtask

   initial begin : watchdog
      #1000000;
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check("R1");   // reset state
      rst = 1'b0;

      step(8'd200, 8'd100, 4'd0, 1'b1, "R3");
      step(8'hFF, 8'h01, 4'd0, 1'b1, "R3 R11");
      step(8'd5, 8'd7, 4'd1, 1'b1, "R4");
      step(8'd7, 8'd7, 4'd1, 1'b1, "R4 R11");
      step(8'h3C, 8'h00, 4'd4, 1'b1, "R6");
      step(8'h3C, 8'hA5, 4'd4, 1'b1, "R6 b ignored");
      step(8'hF0, 8'h3C, 4'd5, 1'b1, "R5");
      step(8'h81, 8'd8, 4'd6, 1'b1, "R7 count 8");
      step(8'h81, 8'd7, 4'd6, 1'b1, "R7");
      step(8'h81, 8'd200, 4'd7, 1'b1, "R8 large count");
      step(8'h81, 8'd1, 4'd8, 1'b1, "R9 msb wraps");
      step(8'h81, 8'd9, 4'd8, 1'b1, "R9 mod 8");
      step(8'h81, 8'd1, 4'd9, 1'b1, "R10 lsb wraps");
      step(8'hFF, 8'h01, 4'd0, 1'b1, "R3 set carry");
      step(8'h12, 8'h34, 4'd5, 1'b0, "R2 hold");
      step(8'h55, 8'h66, 4'd12, 1'b1, "R12");

      // R1: reset after a nonzero load
      step(8'hF0, 8'hF0, 4'd0, 1'b1, "R3");
      @(negedge clk); rst = 1'b1; load = 1'b0;
      @(negedge clk); rst = 1'b0;
      e_res = '0; e_car = 1'b0; e_zer = 1'b0;
      check("R1");

      for (int i = 0; i < 600; i++) begin
         logic [7:0] a, b;
         logic [3:0] m;
         logic ld;
         a  = 8'($urandom);
         m  = 4'($urandom % 16);
         b  = ($urandom % 2 == 0) ? 8'($urandom % 12) : 8'($urandom);
         ld = ($urandom % 4) != 0;
         step(a, b, m, ld, ld ? tag_of(m) : "R2");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule